// File: doc/BRIEF.md
# Fixed-Width Music Command Sequencer

The sequencer plays back a music command stream held in a ROM and turns it into register writes for a sound unit. Every ROM word is 24 bits wide and holds one whole command: an opcode byte and two operand bytes. Commands that are naturally a single opcode byte were padded to this width before the ROM was built. Because every command occupies one word, the sequencer fetches and executes one command per clock cycle, with no byte-serial parsing and no fetch cache.

Three kinds of command are understood: a register write, a family of waits measured in sample ticks, and an end marker. A wait stalls the stream until the requested number of `tick_i` strobes has arrived. The end marker parks the sequencer with `done_o` raised. A `start_i` pulse always restarts playback from ROM address zero and drops any wait in progress. Opcodes outside the known set are skipped in one cycle.

Top module: `music_cmd_seq`

## Requirements
- R1: After reset and until the first `start_i` pulse, `rom_addr_o` is 0, `done_o` is 0 and `reg_wr_o` stays 0 whatever the ROM holds.
- R2: The word on `rom_data_i` is read as opcode in bits 23:16, first operand in bits 15:8 and second operand in bits 7:0; it is taken as the content of the word at the current `rom_addr_o` in the same cycle.
- R3: Opcode 0xB3 executed at clock edge e gives `reg_wr_o` = 1 for exactly the cycle after edge e, with `reg_addr_o` = 0xFF10 + first operand and `reg_data_o` = second operand.
- R4: With no wait pending, commands execute one per clock edge and `rom_addr_o` advances by one per executed command; the first command (address 0) executes on the edge after the one that samples `start_i`.
- R5: Opcode 0x61 waits N sample ticks, N = second operand × 256 + first operand; N = 0 behaves as a one-cycle no-op.
- R6: Opcode 0x62 waits 735 sample ticks and opcode 0x63 waits 882 sample ticks.
- R7: Opcodes 0x70 to 0x7F wait (opcode bits 3:0) + 1 sample ticks.
- R8: During a wait only edges that sample `tick_i` = 1 count; if a wait executes at edge e and its Nth counted tick is sampled at edge t, the next command executes at edge t + 1. Ticks outside a wait have no effect.
- R9: Opcode 0x66 executed at edge e raises `done_o` after edge e; from then on `rom_addr_o` holds the address of that command, no write is issued, and `done_o` stays 1 until `start_i`.
- R10: Any opcode other than 0xB3, 0x61, 0x62, 0x63, 0x66 and 0x70 to 0x7F is skipped in one cycle with no write.
- R11: A `start_i` pulse, in any state including during a wait or after the end marker, sets `rom_addr_o` to 0, clears `done_o`, discards any pending wait, and playback resumes at address 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart playback from address 0 |
| tick_i | input | 1 | Sample-rate tick strobe, one cycle per tick |
| rom_addr_o | output | ADDR_W | Word address of the current command |
| rom_data_i | input | 24 | Command word at `rom_addr_o` |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | REG_AW | Sound-unit register address |
| reg_data_o | output | 8 | Sound-unit register data |
| done_o | output | 1 | End marker reached |

## Verification
The assertions assume the ROM answers combinationally with a defined word at every address, so `rom_data_i` always describes the command at `rom_addr_o`, and that `tick_i` and `start_i` are single-cycle or level strobes sampled only at the clock edge. The bench models the ROM as an array read directly by `rom_addr_o` and fills every unused location with the end marker, so runs cannot walk into undefined words. Tick patterns are either one per cycle or one every third edge, driven on the falling edge, which lets the bench predict the exact edge of every write and of `done_o` from the command list alone.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int unsigned CMD_W  = 24;
  localparam int unsigned WAIT_W = 16;

  localparam logic [7:0] OPC_WRITE    = 8'hB3;
  localparam logic [7:0] OPC_WAIT_N   = 8'h61;
  localparam logic [7:0] OPC_WAIT_735 = 8'h62;
  localparam logic [7:0] OPC_WAIT_882 = 8'h63;
  localparam logic [7:0] OPC_END      = 8'h66;
  localparam logic [3:0] OPC_SHORT_HI = 4'h7;

  localparam logic [WAIT_W-1:0] LEN_735 = 16'd735;
  localparam logic [WAIT_W-1:0] LEN_882 = 16'd882;

  typedef enum logic [1:0] {
    K_NOP,
    K_WRITE,
    K_WAIT,
    K_END
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e         kind;
    logic [WAIT_W-1:0] wait_len;
    logic [7:0]        reg_off;
    logic [7:0]        reg_dat;
  } cmd_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/msq_cmd_decode.sv
module msq_cmd_decode
  import msq_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_t             cmd_o
);
  logic [7:0] opc, op_lo, op_hi;

  assign opc   = word_i[23:16];
  assign op_lo = word_i[15:8];
  assign op_hi = word_i[7:0];

  always_comb begin
    cmd_o          = '0;
    cmd_o.kind     = K_NOP;
    cmd_o.reg_off  = op_lo;
    cmd_o.reg_dat  = op_hi;
    cmd_o.wait_len = '0;
    if (opc == OPC_WRITE) begin
      cmd_o.kind = K_WRITE;
    end else if (opc == OPC_END) begin
      cmd_o.kind = K_END;
    end else if (opc == OPC_WAIT_N) begin
      // little-endian length; zero length degrades to a no-op
      cmd_o.wait_len = {op_hi, op_lo};
      cmd_o.kind     = (|{op_hi, op_lo}) ? K_WAIT : K_NOP;
    end else if (opc == OPC_WAIT_735) begin
      cmd_o.wait_len = LEN_735;
      cmd_o.kind     = K_WAIT;
    end else if (opc == OPC_WAIT_882) begin
      cmd_o.wait_len = LEN_882;
      cmd_o.kind     = K_WAIT;
    end else if (opc[7:4] == OPC_SHORT_HI) begin
      cmd_o.wait_len = {{(WAIT_W-4){1'b0}}, opc[3:0]} + {{(WAIT_W-1){1'b0}}, 1'b1};
      cmd_o.kind     = K_WAIT;
    end
  end
endmodule

// File: rtl/msq_wait_timer.sv
module msq_wait_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         busy_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign busy_o = (cnt_q != '0);

  p_hold_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !clear_i && !load_i) |=> $stable(cnt_q));
  p_count_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && !clear_i && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));
  p_load_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));
  p_load_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !busy_o);
endmodule

// File: rtl/msq_fetch_ctrl.sv
module msq_fetch_ctrl
  import msq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_kind_e         kind_i,
  input  logic              wait_busy_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              exec_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;

  // start wins over the command in flight
  assign exec_o = (state_q == S_RUN) && !wait_busy_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
    end else if (start_i) begin
      state_q <= S_RUN;
      addr_q  <= '0;
    end else if (exec_o) begin
      if (kind_i == K_END) begin
        state_q <= S_DONE;
      end else begin
        addr_q <= addr_q + ADDR_ONE;
      end
    end
  end

  assign rom_addr_o = addr_q;
  assign done_o     = (state_q == S_DONE);

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_IDLE) && !start_i) |=> ((state_q == S_IDLE) && (rom_addr_o == '0)));
  p_start_addr_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((rom_addr_o == '0) && !done_o));
  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((rom_addr_o == $past(rom_addr_o)) || (rom_addr_o == $past(rom_addr_o) + ADDR_ONE)));
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(rom_addr_o)));
  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_busy_i && !start_i) |=> $stable(rom_addr_o));
endmodule

// File: rtl/msq_reg_port.sv
module msq_reg_port #(
  parameter int unsigned           REG_AW   = 16,
  parameter logic [REG_AW-1:0]     REG_BASE = 16'hFF10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        off_i,
  input  logic [7:0]        dat_i,
  output logic              reg_wr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_data_o
);
  localparam logic [REG_AW-1:0] WIN_TOP = {{(REG_AW-8){1'b0}}, 8'hFF};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_wr_o   <= 1'b0;
      reg_addr_o <= '0;
      reg_data_o <= '0;
    end else begin
      reg_wr_o <= wr_en_i;
      if (wr_en_i) begin
        reg_addr_o <= REG_BASE + {{(REG_AW-8){1'b0}}, off_i};
        reg_data_o <= dat_i;
      end
    end
  end

  p_addr_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> ((reg_addr_o - REG_BASE) <= WIN_TOP));
  p_wr_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (reg_wr_o && (reg_data_o == $past(dat_i))));
endmodule

// File: rtl/music_cmd_seq.sv
module music_cmd_seq
  import msq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       REG_AW   = 16,
  parameter logic [REG_AW-1:0] REG_BASE = 16'hFF10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [CMD_W-1:0]  rom_data_i,
  output logic              reg_wr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_data_o,
  output logic              done_o
);
  cmd_t cmd;
  logic exec, wait_busy;

  msq_cmd_decode u_dec (
    .word_i (rom_data_i),
    .cmd_o  (cmd)
  );

  msq_fetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .kind_i      (cmd.kind),
    .wait_busy_i (wait_busy),
    .rom_addr_o  (rom_addr_o),
    .exec_o      (exec),
    .done_o      (done_o)
  );

  msq_wait_timer #(.W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_i),
    .load_i     (exec && (cmd.kind == K_WAIT)),
    .load_val_i (cmd.wait_len),
    .tick_i     (tick_i),
    .busy_o     (wait_busy)
  );

  msq_reg_port #(.REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (exec && (cmd.kind == K_WRITE)),
    .off_i      (cmd.reg_off),
    .dat_i      (cmd.reg_dat),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .reg_data_o (reg_data_o)
  );

  p_no_write_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !reg_wr_o);
  p_wait_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_busy && $past(wait_busy)) |-> !reg_wr_o);
endmodule

// File: tb/music_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module music_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  rom_addr;
  logic [23:0] rom_data;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [7:0]  reg_data;
  logic        done;

  logic [23:0] rom [0:255];
  assign rom_data = rom[rom_addr];

  always #2 clk = ~clk;

  music_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick),
    .rom_addr_o(rom_addr), .rom_data_i(rom_data),
    .reg_wr_o(reg_wr), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .done_o(done)
  );

  int n_chk = 0, n_err = 0;
  int ecnt = 0;
  int tick_mode = 0;
  int cur_s = 1000000;
  bit finished = 0;

  int n_log = 0, log_e [64];
  logic [15:0] log_a [64];
  logic [7:0]  log_d [64];
  int done_edge = -1;

  int n_exp = 0, exp_e [64];
  logic [15:0] exp_a [64];
  logic [7:0]  exp_d [64];
  int exp_done_edge, exp_end_addr;

  always @(posedge clk) ecnt <= ecnt + 1;

  function automatic bit tick_at(input int e);
    case (tick_mode)
      0: return 1'b1;
      1: return (e % 3) == 0;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    tick = tick_at(ecnt);
    if (ecnt - 1 > cur_s) begin
      if (reg_wr && n_log < 64) begin
        log_e[n_log] = ecnt - 1;
        log_a[n_log] = reg_addr;
        log_d[n_log] = reg_data;
        n_log++;
      end
      if (done && done_edge < 0) done_edge = ecnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic bit is_known(input logic [7:0] op);
    return op == 8'hB3 || op == 8'h61 || op == 8'h62 || op == 8'h63 ||
           op == 8'h66 || op[7:4] == 4'h7;
  endfunction

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 24'h660000;
  endtask

  task automatic put(input int idx, input logic [7:0] op, input logic [7:0] a,
                     input logic [7:0] b);
    rom[idx] = {op, a, b};
  endtask

  // expected write/done timeline from the command list (R3..R10)
  task automatic build_expect(input int s);
    int e, a, len, cnt, t;
    logic [7:0] op, o1, o2;
    e = s + 1; a = 0; n_exp = 0;
    exp_done_edge = -1; exp_end_addr = -1;
    for (int guard = 0; guard < 300; guard++) begin
      op = rom[a][23:16]; o1 = rom[a][15:8]; o2 = rom[a][7:0];
      if (op == 8'hB3) begin
        exp_e[n_exp] = e; exp_a[n_exp] = 16'hFF10 + {8'h00, o1}; exp_d[n_exp] = o2;
        n_exp++; e++; a++;
      end else if (op == 8'h66) begin
        exp_done_edge = e; exp_end_addr = a;
        break;
      end else begin
        if (op == 8'h61) len = {o2, o1};
        else if (op == 8'h62) len = 735;
        else if (op == 8'h63) len = 882;
        else if (op[7:4] == 4'h7) len = op[3:0] + 1;
        else len = 0;
        if (len == 0) begin
          e++; a++;
        end else begin
          cnt = 0; t = e;
          while (cnt < len) begin
            t++;
            if (tick_at(t)) cnt++;
          end
          e = t + 1; a++;
        end
      end
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    cur_s = ecnt;
    n_log = 0; done_edge = -1;
    build_expect(ecnt);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input string tag);
    int held;
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    held = n_log;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(done == 1'b1, tag, "done held (R9)", done, 1);
    end
    chk(n_log == held, tag, "no write after end (R9)", n_log, held);
    chk(rom_addr == exp_end_addr[7:0], tag, "address parked at end (R9)", rom_addr, exp_end_addr);
    chk(done_edge == exp_done_edge, tag, "done edge (R9)", done_edge, exp_done_edge);
    chk(n_log == n_exp, tag, "write count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(log_e[i] == exp_e[i], tag, "write edge (R4/R8)", log_e[i], exp_e[i]);
      chk(log_a[i] == exp_a[i], tag, "write address (R2/R3)", log_a[i], exp_a[i]);
      chk(log_d[i] == exp_d[i], tag, "write data (R3)", log_d[i], exp_d[i]);
    end
  endtask

  task automatic run_prog(input string tag, input int mode);
    tick_mode = mode;
    do_start();
    finish_run(tag);
  endtask

  always @(posedge clk) begin
    if (ecnt > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", ecnt);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int idx;
    clear_rom();
    put(0, 8'hB3, 8'h01, 8'h5A);
    put(1, 8'hB3, 8'h02, 8'h5B);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // r1_ reset and idle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rom_addr == 8'd0, "R1", "idle address", rom_addr, 0);
      chk(done == 1'b0, "R1", "idle done", done, 0);
      chk(reg_wr == 1'b0, "R1", "idle strobe", reg_wr, 0);
    end

    // R3/R4: back-to-back writes, offset extremes
    clear_rom();
    for (int i = 0; i < 8; i++) put(i, 8'hB3, (i == 7) ? 8'hFF : 8'(i * 37), 8'(8'hC0 ^ i));
    put(8, 8'h66, 8'h00, 8'h00);
    run_prog("R3", 0);
    // R11: restart after end
    run_prog("R11", 1);

    // R10: unknown opcode sweep, both halves
    for (int half = 0; half < 2; half++) begin
      clear_rom();
      idx = 0;
      for (int op = half * 128; op < half * 128 + 128; op++) begin
        if (!is_known(8'(op))) begin
          put(idx, 8'(op), 8'(op), 8'(~op));
          idx++;
        end
      end
      put(idx, 8'hB3, 8'h55, 8'hAA);
      put(idx + 1, 8'h66, 8'h00, 8'h00);
      run_prog("R10", 0);
    end

    // R7/R8: every short wait, sparse ticks
    clear_rom();
    for (int k = 0; k < 16; k++) begin
      put(2 * k, 8'(8'h70 + k), 8'hEE, 8'hEE);
      put(2 * k + 1, 8'hB3, 8'(k), 8'(k * 3));
    end
    put(32, 8'h66, 8'h00, 8'h00);
    run_prog("R7", 1);
    run_prog("R8", 0);

    // R5: long-form wait, including zero and multi-byte lengths
    clear_rom();
    put(0, 8'h61, 8'h00, 8'h00);
    put(1, 8'hB3, 8'h10, 8'h01);
    put(2, 8'h61, 8'h01, 8'h00);
    put(3, 8'hB3, 8'h11, 8'h02);
    put(4, 8'h61, 8'h03, 8'h01);
    put(5, 8'hB3, 8'h12, 8'h03);
    put(6, 8'h61, 8'h05, 8'h00);
    put(7, 8'hB3, 8'h13, 8'h04);
    put(8, 8'h66, 8'h00, 8'h00);
    run_prog("R5", 1);
    run_prog("R5", 0);

    // R6: fixed long waits
    clear_rom();
    put(0, 8'hB3, 8'h20, 8'h11);
    put(1, 8'h62, 8'h00, 8'h00);
    put(2, 8'hB3, 8'h21, 8'h22);
    put(3, 8'h63, 8'h00, 8'h00);
    put(4, 8'hB3, 8'h22, 8'h33);
    put(5, 8'h66, 8'h00, 8'h00);
    run_prog("R6", 0);

    // R11: start during a pending wait
    clear_rom();
    put(0, 8'hB3, 8'h05, 8'h77);
    put(1, 8'h61, 8'hE8, 8'h03);
    put(2, 8'hB3, 8'h06, 8'h88);
    put(3, 8'h66, 8'h00, 8'h00);
    tick_mode = 0;
    do_start();
    repeat (20) @(negedge clk);
    chk(n_log == 1, "R8", "single write before wait expires", n_log, 1);
    chk(rom_addr == 8'd2, "R8", "address stalled after wait", rom_addr, 2);
    chk(done == 1'b0, "R8", "not done in wait", done, 0);
    run_prog("R11", 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule